// File: doc/BRIEF.md
# Neighbor-Aware Zero-Suppressed Channel Readout

This block collects one event's worth of hits from a bank of front-end channels and sends out only the channels that matter. Each channel supplies a hit flag, a digitized peak amplitude and a digitized peak time. An acquisition-end strobe freezes the hit pattern and the data. The block then works out which channels to read. These are the hit channels and, when neighbor marking is on, the channels directly beside each hit.

The marked channels leave one word per channel on a valid/ready stream, from the lowest address to the highest. Each word carries the channel address, the amplitude and the time, and the final word of the event carries an end flag. Unmarked channels produce nothing.

Two bidirectional edge pins pass hit status to the adjacent chips. Channel 0 uses the low-side pin and the last channel uses the high-side pin. A neighbor chip's hit on a pin therefore pulls that edge channel into the readout.

Top module: `nbr_sparse_readout`

## Requirements
- R1: After reset, out_valid and out_last are low.
- R2: With nbr_mode low, a channel is read out exactly when its hit_i bit was high at the accepted strobe.
- R3: With nbr_mode high, a channel is also read out when the channel one address below or above it (inside the chip) was hit.
- R4: With nbr_mode high, a high level on edge_lo at the strobe marks channel 0, and a high level on edge_hi marks the highest channel. With nbr_mode low, both pins are ignored.
- R5: While edge_drive_en is high, edge_lo carries hit_i[0] and edge_hi carries the highest hit_i bit. While it is low, the block leaves both pins undriven.
- R6: Each marked channel produces exactly one word, in ascending address order. The word is {address (top 6 bits for 64 channels), amplitude, time (lowest bits)}, and the amplitude and time are the values present at the strobe.
- R7: out_last is high with the final word of an event and low with every other word.
- R8: While out_valid is high and out_ready is low, out_valid, out_data and out_last hold their values.
- R9: A strobe is ignored while a word is presented or words are still pending, and input changes after an accepted strobe do not alter that event's words.
- R10: An accepted strobe with no marked channel produces no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nbr_mode | input | 1 | Also mark the neighbors of hit channels |
| edge_drive_en | input | 1 | Drive the edge pins with the edge channels' hits |
| acq_end | input | 1 | Acquisition-end strobe, latches hits and data |
| hit_i | input | NCH | Per-channel over-threshold flags |
| amp_i | input | NCH*AMP_W | Flattened peak amplitudes, channel c at [c*AMP_W +: AMP_W] |
| time_i | input | NCH*TIME_W | Flattened peak times, channel c at [c*TIME_W +: TIME_W] |
| edge_lo | inout | 1 | Hit exchange with the chip below channel 0 |
| edge_hi | inout | 1 | Hit exchange with the chip above the highest channel |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | ADDR_W+AMP_W+TIME_W | Address, amplitude, time |
| out_last | output | 1 | Final word of the event |

## Verification
The stream assertions assume the consumer behaves as a valid/ready sink. They also assume a strobe cannot start a new event while out_valid is high, which is what lets an accepted final word be followed by an idle cycle. The bench drives the edge pins from its side only while edge_drive_en is low, so there is never a conflict on the pins. It pulses acq_end during readouts to exercise the ignore rule. It throttles out_ready irregularly, so the hold and ordering properties are seen under stalls as well as under back-to-back acceptance.

// File: rtl/nsr_pkg.sv
package nsr_pkg;
   localparam int unsigned NSR_DEF_NCH    = 64;
   localparam int unsigned NSR_DEF_AMP_W  = 10;
   localparam int unsigned NSR_DEF_TIME_W = 8;
   localparam int unsigned NSR_MIN_NCH    = 4;
endpackage

// File: rtl/nsr_pri_enc.sv
module nsr_pri_enc #(
   parameter int unsigned N      = 64,
   parameter int unsigned IDX_W  = $clog2(N)
) (
   input  logic [N-1:0]     vec,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   if (N < 2) begin : g_bad_n
      $error("nsr_pri_enc: N must be at least 2");
   end

   always_comb begin
      idx = '0;
      any = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            idx = IDX_W'(i);
            any = 1'b1;
         end
      end
   end
endmodule

// File: rtl/nsr_mark_latch.sv
module nsr_mark_latch #(
   parameter int unsigned NCH    = 64,
   parameter int unsigned AMP_W  = 10,
   parameter int unsigned TIME_W = 8,
   localparam int unsigned ADDR_W = $clog2(NCH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic                    nbr_mode,
   input  logic [NCH-1:0]          hit_i,
   input  logic                    edge_lo_in,
   input  logic                    edge_hi_in,
   input  logic [NCH*AMP_W-1:0]    amp_i,
   input  logic [NCH*TIME_W-1:0]   time_i,
   input  logic                    clr_en,
   input  logic [ADDR_W-1:0]       clr_idx,
   output logic [NCH-1:0]          mark,
   output logic [NCH*AMP_W-1:0]    amp_q,
   output logic [NCH*TIME_W-1:0]   time_q
);
   logic [NCH-1:0] side_hit;
   logic [NCH-1:0] new_mark;
   logic [NCH-1:0] clr_mask;

   for (genvar c = 0; c < NCH; c++) begin : g_side
      logic below, above;
      if (c == 0) begin : g_lo_edge
         assign below = edge_lo_in;
      end else begin : g_lo_in
         assign below = hit_i[c-1];
      end
      if (c == NCH - 1) begin : g_hi_edge
         assign above = edge_hi_in;
      end else begin : g_hi_in
         assign above = hit_i[c+1];
      end
      assign side_hit[c] = below | above;
   end

   assign new_mark = hit_i | (nbr_mode ? side_hit : '0);
   assign clr_mask = clr_en ? (NCH'(1) << clr_idx) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mark <= '0;
      end else if (load) begin
         mark <= new_mark;
      end else begin
         mark <= mark & ~clr_mask;
      end
   end

   always_ff @(posedge clk) begin
      if (load) begin
         amp_q  <= amp_i;
         time_q <= time_i;
      end
   end
endmodule

// File: rtl/nsr_out_stage.sv
module nsr_out_stage #(
   parameter int unsigned NCH    = 64,
   parameter int unsigned AMP_W  = 10,
   parameter int unsigned TIME_W = 8,
   localparam int unsigned ADDR_W = $clog2(NCH),
   localparam int unsigned WORD_W = ADDR_W + AMP_W + TIME_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NCH-1:0]        mark,
   input  logic [NCH*AMP_W-1:0]  amp_q,
   input  logic [NCH*TIME_W-1:0] time_q,
   output logic                  clr_en,
   output logic [ADDR_W-1:0]     clr_idx,
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [WORD_W-1:0]     out_data,
   output logic                  out_last
);
   logic              any;
   logic [ADDR_W-1:0] idx;
   logic              adv;
   logic [NCH-1:0]    rest;

   nsr_pri_enc #(.N(NCH), .IDX_W(ADDR_W)) u_enc (
      .vec (mark),
      .idx (idx),
      .any (any)
   );

   assign adv     = !out_valid || out_ready;
   assign clr_en  = adv && any;
   assign clr_idx = idx;
   assign rest    = mark & ~(NCH'(1) << idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         out_data  <= '0;
      end else if (adv) begin
         out_valid <= any;
         if (any) begin
            out_data <= {idx, amp_q[idx*AMP_W +: AMP_W], time_q[idx*TIME_W +: TIME_W]};
            out_last <= (rest == '0);
         end else begin
            out_last <= 1'b0;
         end
      end
   end

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

   assert_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !out_last) |=>
         (out_valid && (out_data[WORD_W-1 -: ADDR_W] > $past(out_data[WORD_W-1 -: ADDR_W]))));

   assert_cont_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |=> out_valid);

   assert_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> !out_valid);
endmodule

// File: rtl/nbr_sparse_readout.sv
module nbr_sparse_readout #(
   parameter int unsigned NCH    = nsr_pkg::NSR_DEF_NCH,
   parameter int unsigned AMP_W  = nsr_pkg::NSR_DEF_AMP_W,
   parameter int unsigned TIME_W = nsr_pkg::NSR_DEF_TIME_W,
   localparam int unsigned ADDR_W = $clog2(NCH),
   localparam int unsigned WORD_W = ADDR_W + AMP_W + TIME_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  nbr_mode,
   input  logic                  edge_drive_en,
   input  logic                  acq_end,
   input  logic [NCH-1:0]        hit_i,
   input  logic [NCH*AMP_W-1:0]  amp_i,
   input  logic [NCH*TIME_W-1:0] time_i,
   inout  wire                   edge_lo,
   inout  wire                   edge_hi,
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [WORD_W-1:0]     out_data,
   output logic                  out_last
);
   if (NCH < nsr_pkg::NSR_MIN_NCH || (NCH & (NCH - 1)) != 0) begin : g_bad_nch
      $error("nbr_sparse_readout: NCH must be a power of two, at least 4");
   end
   if (AMP_W < 1 || TIME_W < 1) begin : g_bad_w
      $error("nbr_sparse_readout: data widths must be positive");
   end

   logic [NCH-1:0]        mark;
   logic [NCH*AMP_W-1:0]  amp_q;
   logic [NCH*TIME_W-1:0] time_q;
   logic                  clr_en;
   logic [ADDR_W-1:0]     clr_idx;
   logic                  busy;
   logic                  load;

   assign edge_lo = edge_drive_en ? hit_i[0]     : 1'bz;
   assign edge_hi = edge_drive_en ? hit_i[NCH-1] : 1'bz;

   assign busy = out_valid || (mark != '0);
   assign load = acq_end && !busy;

   nsr_mark_latch #(.NCH(NCH), .AMP_W(AMP_W), .TIME_W(TIME_W)) u_mark (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .nbr_mode   (nbr_mode),
      .hit_i      (hit_i),
      .edge_lo_in (edge_lo),
      .edge_hi_in (edge_hi),
      .amp_i      (amp_i),
      .time_i     (time_i),
      .clr_en     (clr_en),
      .clr_idx    (clr_idx),
      .mark       (mark),
      .amp_q      (amp_q),
      .time_q     (time_q)
   );

   nsr_out_stage #(.NCH(NCH), .AMP_W(AMP_W), .TIME_W(TIME_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .mark      (mark),
      .amp_q     (amp_q),
      .time_q    (time_q),
      .clr_en    (clr_en),
      .clr_idx   (clr_idx),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .out_last  (out_last)
   );

   assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_end && out_valid && !out_ready) |=> out_valid);
endmodule

// File: tb/tb_nbr_sparse_readout.sv
module tb_nbr_sparse_readout;
   localparam int NCH = 64, AMP_W = 10, TIME_W = 8, ADDR_W = 6;
   localparam int WORD_W = ADDR_W + AMP_W + TIME_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic nbr_mode = 1'b0, edge_drive_en = 1'b0, acq_end = 1'b0, out_ready = 1'b1;
   logic [NCH-1:0] hit_i = '0;
   logic [NCH*AMP_W-1:0] amp_i = '0;
   logic [NCH*TIME_W-1:0] time_i = '0;
   logic tb_lo = 1'b0, tb_hi = 1'b0;
   wire pin_lo, pin_hi;
   logic out_valid, out_last;
   logic [WORD_W-1:0] out_data;

   assign pin_lo = edge_drive_en ? 1'bz : tb_lo;
   assign pin_hi = edge_drive_en ? 1'bz : tb_hi;

   always #2.5 clk = ~clk;

   nbr_sparse_readout dut (
      .clk(clk), .rst_n(rst_n), .nbr_mode(nbr_mode), .edge_drive_en(edge_drive_en),
      .acq_end(acq_end), .hit_i(hit_i), .amp_i(amp_i), .time_i(time_i),
      .edge_lo(pin_lo), .edge_hi(pin_hi), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_last(out_last)
   );

   int checks = 0, fails = 0;
   bit stall_en = 1'b0;

   // behavioural reference: a queue of pending words and one presented word
   logic [WORD_W-1:0] q[$];
   logic m_valid = 1'b0, m_last = 1'b0;
   logic [WORD_W-1:0] m_word = '0;
   int got[$];
   int last_cnt = 0, last_pos = -1;

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete(); m_valid = 1'b0; m_last = 1'b0;
      end else begin
         bit busy_m;
         if (out_valid && out_ready) begin
            got.push_back(int'(out_data[WORD_W-1 -: ADDR_W]));
            if (out_last) begin last_cnt++; last_pos = got.size(); end
         end
         busy_m = m_valid || (q.size() > 0);
         if (!m_valid || out_ready) begin
            if (q.size() > 0) begin
               m_word = q.pop_front(); m_last = (q.size() == 0); m_valid = 1'b1;
            end else m_valid = 1'b0;
         end
         if (acq_end && !busy_m) begin
            logic lo_v, hi_v;
            lo_v = edge_drive_en ? hit_i[0] : tb_lo;
            hi_v = edge_drive_en ? hit_i[NCH-1] : tb_hi;
            for (int c = 0; c < NCH; c++) begin
               bit m;
               m = hit_i[c];
               if (nbr_mode) begin
                  if (c > 0 && hit_i[c-1]) m = 1;
                  if (c < NCH-1 && hit_i[c+1]) m = 1;
                  if (c == 0 && lo_v) m = 1;
                  if (c == NCH-1 && hi_v) m = 1;
               end
               if (m) q.push_back({ADDR_W'(c), amp_i[c*AMP_W +: AMP_W], time_i[c*TIME_W +: TIME_W]});
            end
         end
      end
   end

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (out_valid !== m_valid || (m_valid && (out_data !== m_word || out_last !== m_last))) begin
            fails++;
            $display("FAIL R6 stream: valid=%b data=%h last=%b expected valid=%b data=%h last=%b",
                     out_valid, out_data, out_last, m_valid, m_word, m_last);
         end
      end
      if (stall_en) out_ready <= ($urandom % 4) != 0;
      else out_ready <= 1'b1;
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic set_data(input int seed);
      for (int c = 0; c < NCH; c++) begin
         amp_i[c*AMP_W +: AMP_W]   = AMP_W'(c * 13 + seed);
         time_i[c*TIME_W +: TIME_W] = TIME_W'(c ^ seed);
      end
   endtask

   task automatic run_event(input string tag, input logic [63:0] hits, input bit nbr,
                            input bit den, input bit lo, input bit hi,
                            input bit mid_strobe, input logic [63:0] exp_mask);
      logic [63:0] got_mask;
      bit ordered;
      int prev;
      @(negedge clk);
      got.delete(); last_cnt = 0; last_pos = -1;
      hit_i = hits; nbr_mode = nbr; edge_drive_en = den; tb_lo = lo; tb_hi = hi;
      acq_end = 1'b1;
      @(negedge clk);
      acq_end = 1'b0;
      // R9: changes after the accepted strobe must not matter
      hit_i = ~hits; set_data(99); tb_lo = 1'b1; tb_hi = 1'b1;
      @(negedge clk);
      @(negedge clk);
      if (mid_strobe && out_valid) begin
         acq_end = 1'b1; @(negedge clk); acq_end = 1'b0;
      end
      while (out_valid) @(negedge clk);
      repeat (3) @(negedge clk);
      got_mask = '0; ordered = 1; prev = -1;
      foreach (got[i]) begin
         got_mask[got[i]] = 1'b1;
         if (got[i] <= prev) ordered = 0;
         prev = got[i];
      end
      chk(tag, got_mask, exp_mask);
      chk("R6 ascending, once each", 64'(ordered), 64'd1);
      chk("R7 end flag count", 64'(last_cnt), (exp_mask == 0) ? 64'd0 : 64'd1);
      if (exp_mask != 0) chk("R7 end flag on final word", 64'(last_pos), 64'(got.size()));
      hit_i = '0; tb_lo = 1'b0; tb_hi = 1'b0; set_data(3);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      set_data(3);
      repeat (4) @(negedge clk);
      chk("R1 reset valid", 64'(out_valid), 64'd0);
      chk("R1 reset last", 64'(out_last), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", 64'(out_valid), 64'd0);

      run_event("R2 normal mode", (64'd1 << 5) | (64'd1 << 9) | (64'd1 << 40), 0, 0, 0, 0, 0,
                (64'd1 << 5) | (64'd1 << 9) | (64'd1 << 40));
      run_event("R3 neighbor mode", (64'd1 << 5) | (64'd1 << 6) | (64'd1 << 20), 1, 0, 0, 0, 0,
                64'h0000_0000_0038_00F0);
      run_event("R3 edge channels", (64'd1 << 0) | (64'd1 << 63), 1, 0, 0, 0, 0,
                (64'd1 << 0) | (64'd1 << 1) | (64'd1 << 62) | (64'd1 << 63));
      run_event("R4 pins mark edges", 64'd0, 1, 0, 1, 1, 0, (64'd1 << 0) | (64'd1 << 63));
      run_event("R4 pins ignored in normal mode", 64'd0, 0, 0, 1, 1, 0, 64'd0);
      run_event("R10 empty event", 64'd0, 1, 0, 0, 0, 0, 64'd0);
      stall_en = 1'b1;
      run_event("R8 stalled readout", 64'hF000_0000_0001_0101, 0, 0, 0, 0, 0, 64'hF000_0000_0001_0101);
      run_event("R9 strobe while busy", (64'd1 << 10) | (64'd1 << 11) | (64'd1 << 12), 0, 0, 0, 0, 1,
                (64'd1 << 10) | (64'd1 << 11) | (64'd1 << 12));
      stall_en = 1'b0;

      // R5 pin drive
      @(negedge clk);
      edge_drive_en = 1'b1; hit_i[0] = 1'b1; hit_i[63] = 1'b0;
      @(negedge clk);
      chk("R5 low pin driven high", 64'(pin_lo), 64'd1);
      chk("R5 high pin driven low", 64'(pin_hi), 64'd0);
      hit_i[0] = 1'b0; hit_i[63] = 1'b1;
      @(negedge clk);
      chk("R5 low pin driven low", 64'(pin_lo), 64'd0);
      chk("R5 high pin driven high", 64'(pin_hi), 64'd1);
      edge_drive_en = 1'b0; tb_lo = 1'b1; tb_hi = 1'b0;
      @(negedge clk);
      chk("R5 low pin released", 64'(pin_lo), 64'd1);
      chk("R5 high pin released", 64'(pin_hi), 64'd0);
      hit_i = '0; tb_lo = 1'b0;

      run_event("R4 pin driven by block", (64'd1 << 0), 1, 1, 0, 0, 0, (64'd1 << 0) | (64'd1 << 1));

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule